// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits on a byte-wide receive path behind the preamble stripper and decides, frame by frame, whether what arrived is worth keeping. The first valid byte of a frame must be the start-of-frame delimiter. The bytes after it (destination address through frame check sequence) are passed on to a DMA-style sink, one byte per beat. At the end of the frame a done strobe carries a good/bad verdict, so the sink can keep the buffer or take it back.

When a frame goes bad while it is still arriving, the block cuts the byte stream at once and pulses an abort, so the sink stops writing. A frame can go bad by growing past the size limit or by a receive-error strobe. The CRC-32 keeps running after an abort, so an oversize frame can still be sorted into long or jabber. At each end of frame the block raises one-cycle increment pulses for an external set of statistics counters. A jumbo mode raises the size limit. The mode is sampled at the delimiter of each frame.

Top module: `rx_frame_checker`

## Requirements
- R1: After reset, every output is 0: out_valid_o, abort_o, done_o, good_o and all seven statistics pulses.
- R2: The first valid beat of a frame is its delimiter, which must be 0xD5. Any other value discards the frame. A discarded frame streams no bytes, gives no abort and no statistics pulse, and ends with done_o=1, good_o=0.
- R3: For a live frame, each byte after the delimiter appears on out_data_o with out_valid_o=1 exactly one cycle after its input beat. A cycle with rx_valid_i=0 produces no output strobe.
- R4: rx_err_i is sampled only with rx_valid_i. On the first errored beat of a live frame, abort_o pulses one cycle later, that byte and all later bytes of the frame are withheld, and stat_symbol_o pulses at frame end.
- R5: The frame length counts bytes from destination address through FCS. On the beat that takes it past the limit (MAX_STD, or MAX_JUMBO in jumbo mode), abort_o pulses and the stream stops for the rest of the frame.
- R6: done_o pulses one cycle after the beat with rx_eof_i. good_o=1 with it only when all of these hold: the delimiter was right, no receive error occurred, MIN_LEN <= length <= limit, and the CRC check passes.
- R7: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones), taken LSB-first over destination address through FCS. The check passes when the register ends at 0xDEBB20E3, which is 0xC704DD7B in MSB-first form. stat_fcs_o pulses for an in-range frame with no receive error, a failed check and rx_partial_i=0.
- R8: rx_partial_i, given with the last beat, marks a frame that ends on a partial octet. With a failed CRC on an in-range, error-free frame it turns the FCS pulse into stat_align_o. With a passing CRC it changes nothing.
- R9: A frame shorter than MIN_LEN bytes pulses stat_short_o.
- R10: A frame over the limit pulses stat_long_o when its CRC passes and stat_jabber_o when it fails.
- R11: The type/length field is bytes 12 and 13 (0-based), big-endian. For an in-range, error-free frame with a passing CRC and a field below 0x0600, stat_len_mis_o pulses when the field differs from length-18. The exception is a frame of exactly MIN_LEN bytes, where it pulses only when the field exceeds length-18, since the rest is padding.
- R12: jumbo_en_i is latched at each frame's delimiter beat and holds for that frame; the latch is 0 after reset. A change during a frame has no effect on that frame's limit.
- R13: Statistics pulses occur only together with done_o. At most one of align, fcs, short, long and jabber fires per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| jumbo_en_i | input | 1 | Jumbo mode request, sampled at the delimiter |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_eof_i | input | 1 | Last byte of frame, with rx_valid_i |
| rx_err_i | input | 1 | Receive error, with rx_valid_i |
| rx_partial_i | input | 1 | Frame ended on a partial octet, with rx_eof_i |
| out_valid_o | output | 1 | Streamed byte valid |
| out_data_o | output | 8 | Streamed byte |
| abort_o | output | 1 | Frame turned bad mid-reception |
| done_o | output | 1 | End of frame status strobe |
| good_o | output | 1 | Frame good, valid with done_o |
| stat_align_o | output | 1 | Alignment error increment |
| stat_fcs_o | output | 1 | FCS error increment |
| stat_short_o | output | 1 | Short frame increment |
| stat_long_o | output | 1 | Long frame increment |
| stat_jabber_o | output | 1 | Jabber increment |
| stat_symbol_o | output | 1 | Receive symbol error increment |
| stat_len_mis_o | output | 1 | Length field mismatch increment |

## Verification
The bench builds the block with MIN_LEN=64, MAX_STD=96 and MAX_JUMBO=160. This keeps the lengths that cross the standard limit, the jumbo limit and the padded minimum within a few hundred beats. As a result, long, jabber, jumbo acceptance, jumbo overflow and a mode change in mid-frame can all be driven in one short run. The bench also spaces beats with idle cycles that carry a stray receive error. This shows that sampling is qualified by valid and that streaming holds up across gaps.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam logic [7:0]  SFD_BYTE   = 8'hD5;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_GOOD_R = 32'hDEBB20E3;
  localparam int          HDR_FCS    = 18;
  localparam logic [15:0] TYPE_MIN   = 16'h0600;
  localparam int          FIELD_POS  = 12;

  typedef struct packed {
    logic align;
    logic fcs;
    logic short_f;
    logic long_f;
    logic jabber;
    logic symbol;
    logic len_mis;
  } rx_stat_t;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ d[i]) ? CRC_POLY_R : 32'h0);
    return r;
  endfunction
endpackage

// File: rtl/rfc_crc32.sv
module rfc_crc32
  import rfc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic       match_o
);
  logic [31:0] crc_q, crc_nxt;

  assign crc_nxt = crc_step(crc_q, data_i);
  assign match_o = (crc_nxt == CRC_GOOD_R);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_INIT;
    else if (init_i) crc_q <= CRC_INIT;
    else if (en_i)   crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rfc_len_track.sv
module rfc_len_track
  import rfc_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CNT_SAT = 10241
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [7:0]       data_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [15:0]      field_o
);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(CNT_SAT);
  localparam logic [CNT_W-1:0] F_HI  = CNT_W'(FIELD_POS);
  localparam logic [CNT_W-1:0] F_LO  = CNT_W'(FIELD_POS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = (cnt_q == SAT) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      field_o <= '0;
    end else if (init_i) begin
      cnt_q   <= '0;
      field_o <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_nxt_o;
      if (cnt_q == F_HI) field_o[15:8] <= data_i;
      if (cnt_q == F_LO) field_o[7:0]  <= data_i;
    end
  end
endmodule

// File: rtl/rfc_classify.sv
module rfc_classify
  import rfc_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int MIN_LEN = 64
) (
  input  logic [CNT_W-1:0] len_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             crc_ok_i,
  input  logic             err_i,
  input  logic             partial_i,
  input  logic [15:0]      field_i,
  output logic             good_o,
  output rx_stat_t         stat_o
);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] HF    = CNT_W'(HDR_FCS);

  logic in_rng, over, clean_bad, lm_cand;
  logic [31:0] pay, fld;

  assign in_rng    = (len_i >= MIN_L) && (len_i <= limit_i);
  assign over      = len_i > limit_i;
  assign clean_bad = in_rng && !crc_ok_i && !err_i;
  assign pay       = 32'(len_i - HF);
  assign fld       = 32'(field_i);
  assign lm_cand   = in_rng && crc_ok_i && !err_i && (field_i < TYPE_MIN);

  always_comb begin
    good_o         = !err_i && in_rng && crc_ok_i;
    stat_o.short_f = len_i < MIN_L;
    stat_o.long_f  = over && crc_ok_i;
    stat_o.jabber  = over && !crc_ok_i;
    stat_o.fcs     = clean_bad && !partial_i;
    stat_o.align   = clean_bad && partial_i;
    stat_o.symbol  = err_i;
    stat_o.len_mis = lm_cand && ((len_i == MIN_L) ? (fld > pay) : (fld != pay));
  end
endmodule

// File: rtl/rx_frame_checker.sv
module rx_frame_checker
  import rfc_pkg::*;
#(
  parameter int MIN_LEN   = 64,
  parameter int MAX_STD   = 1518,
  parameter int MAX_JUMBO = 10240
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       jumbo_en_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_eof_i,
  input  logic       rx_err_i,
  input  logic       rx_partial_i,
  output logic       out_valid_o,
  output logic [7:0] out_data_o,
  output logic       abort_o,
  output logic       done_o,
  output logic       good_o,
  output logic       stat_align_o,
  output logic       stat_fcs_o,
  output logic       stat_short_o,
  output logic       stat_long_o,
  output logic       stat_jabber_o,
  output logic       stat_symbol_o,
  output logic       stat_len_mis_o
);
  localparam int CNT_SAT = MAX_JUMBO + 1;
  localparam int CNT_W   = $clog2(CNT_SAT + 1);
  localparam logic [CNT_W-1:0] LIM_STD = CNT_W'(MAX_STD);
  localparam logic [CNT_W-1:0] LIM_JMB = CNT_W'(MAX_JUMBO);

  logic in_frame_q, sfd_ok_q, drop_q, er_q, jumbo_q;
  logic start, cont, sfd_hit, live, kill_now, crc_ok, last;
  logic cls_good, sfd_end;
  logic [CNT_W-1:0] cnt_nxt, limit, len_end;
  logic [15:0] field;
  rx_stat_t cls_stat, stat_q;

  assign start   = rx_valid_i && !in_frame_q;
  assign cont    = rx_valid_i && in_frame_q;
  assign last    = rx_valid_i && rx_eof_i;
  assign sfd_hit = rx_data_i == SFD_BYTE;
  assign live    = sfd_ok_q && !drop_q;
  assign limit   = jumbo_q ? LIM_JMB : LIM_STD;
  assign len_end = start ? '0 : cnt_nxt;
  assign sfd_end = start ? sfd_hit : sfd_ok_q;

  // abort on the beat that turns the frame bad, not at its end
  assign kill_now = start ? (sfd_hit && rx_err_i)
                          : (cont && live && (rx_err_i || (cnt_nxt > limit)));

  rfc_crc32 u_crc (
    .clk_i, .rst_ni,
    .init_i (start),
    .en_i   (cont),
    .data_i (rx_data_i),
    .match_o(crc_ok)
  );

  rfc_len_track #(.CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) u_len (
    .clk_i, .rst_ni,
    .init_i   (start),
    .en_i     (cont),
    .data_i   (rx_data_i),
    .cnt_nxt_o(cnt_nxt),
    .field_o  (field)
  );

  rfc_classify #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_cls (
    .len_i    (len_end),
    .limit_i  (limit),
    .crc_ok_i (crc_ok && !start),
    .err_i    (rx_err_i || (cont && er_q)),
    .partial_i(rx_partial_i),
    .field_i  (field),
    .good_o   (cls_good),
    .stat_o   (cls_stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      sfd_ok_q   <= 1'b0;
      drop_q     <= 1'b0;
      er_q       <= 1'b0;
      jumbo_q    <= 1'b0;
    end else if (start) begin
      in_frame_q <= !rx_eof_i;
      sfd_ok_q   <= sfd_hit;
      drop_q     <= sfd_hit && rx_err_i;
      er_q       <= rx_err_i;
      jumbo_q    <= jumbo_en_i;
    end else if (cont) begin
      if (rx_eof_i) in_frame_q <= 1'b0;
      if (kill_now) drop_q <= 1'b1;
      er_q <= er_q || rx_err_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      abort_o     <= 1'b0;
      done_o      <= 1'b0;
      good_o      <= 1'b0;
      stat_q      <= '0;
    end else begin
      out_valid_o <= cont && live && !kill_now;
      if (rx_valid_i) out_data_o <= rx_data_i;
      abort_o <= kill_now;
      done_o  <= last;
      good_o  <= last && sfd_end && cls_good;
      stat_q  <= (last && sfd_end) ? cls_stat : '0;
    end
  end

  assign stat_align_o   = stat_q.align;
  assign stat_fcs_o     = stat_q.fcs;
  assign stat_short_o   = stat_q.short_f;
  assign stat_long_o    = stat_q.long_f;
  assign stat_jabber_o  = stat_q.jabber;
  assign stat_symbol_o  = stat_q.symbol;
  assign stat_len_mis_o = stat_q.len_mis;
endmodule

// File: rtl/rfc_checker.sv
module rfc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rx_eof_i,
  input logic out_valid_o,
  input logic abort_o,
  input logic done_o,
  input logic good_o,
  input logic stat_align_o,
  input logic stat_fcs_o,
  input logic stat_short_o,
  input logic stat_long_o,
  input logic stat_jabber_o,
  input logic stat_symbol_o,
  input logic stat_len_mis_o
);
  logic any_stat;
  assign any_stat = stat_align_o | stat_fcs_o | stat_short_o | stat_long_o |
                    stat_jabber_o | stat_symbol_o | stat_len_mis_o;

  AST_GOOD_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> done_o); // R6
  AST_DONE_AFTER_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_eof_i) |=> done_o); // R6
  AST_GOOD_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> !(stat_short_o | stat_long_o | stat_jabber_o | stat_symbol_o |
                 stat_fcs_o | stat_align_o)); // R6
  AST_ABORT_NO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !out_valid_o); // R4
  AST_ABORT_THEN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !out_valid_o); // R5
  AST_IDLE_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !(out_valid_o || done_o || abort_o)); // R3
  AST_STAT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stat |-> done_o); // R13
  AST_ONE_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({stat_align_o, stat_fcs_o, stat_short_o, stat_long_o, stat_jabber_o})); // R13
endmodule

bind rx_frame_checker rfc_checker u_rfc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_eof_i(rx_eof_i),
  .out_valid_o(out_valid_o), .abort_o(abort_o), .done_o(done_o), .good_o(good_o),
  .stat_align_o(stat_align_o), .stat_fcs_o(stat_fcs_o), .stat_short_o(stat_short_o),
  .stat_long_o(stat_long_o), .stat_jabber_o(stat_jabber_o),
  .stat_symbol_o(stat_symbol_o), .stat_len_mis_o(stat_len_mis_o)
);

// File: tb/sim_rx_frame_checker.sv
module sim_rx_frame_checker;
  localparam int MINL = 64;
  localparam int MAXS = 96;
  localparam int MAXJ = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic jumbo = 1'b0, v = 1'b0, eof = 1'b0, er = 1'b0, part = 1'b0;
  logic [7:0] d = '0;
  logic o_v, o_ab, o_done, o_good, s_al, s_fcs, s_sh, s_lg, s_jb, s_sy, s_lm;
  logic [7:0] o_d;

  always #10 clk = ~clk;

  rx_frame_checker #(.MIN_LEN(MINL), .MAX_STD(MAXS), .MAX_JUMBO(MAXJ)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .jumbo_en_i(jumbo), .rx_valid_i(v), .rx_data_i(d),
    .rx_eof_i(eof), .rx_err_i(er), .rx_partial_i(part),
    .out_valid_o(o_v), .out_data_o(o_d), .abort_o(o_ab), .done_o(o_done), .good_o(o_good),
    .stat_align_o(s_al), .stat_fcs_o(s_fcs), .stat_short_o(s_sh), .stat_long_o(s_lg),
    .stat_jabber_o(s_jb), .stat_symbol_o(s_sy), .stat_len_mis_o(s_lm));

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_in = 0, m_sfd = 0, m_drop = 0, m_er = 0, m_jumbo = 0;
  logic [7:0] mq[$];
  bit e_v, e_ab, e_done, e_good, e_al, e_fcs, e_sh, e_lg, e_jb, e_sy, e_lm;
  logic [7:0] e_d;
  bit gap_on = 0;
  int flip_at = -1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp_v, $time);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input logic [7:0] q[$], input int upto);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < upto; k++)
      for (int b = 0; b < 8; b++) begin
        bit fb = c[0] ^ q[k][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic finish_frame(input bit pt);
    int n, lim, fld, pay;
    bit crc_ok, in_rng;
    n = mq.size();
    lim = m_jumbo ? MAXJ : MAXS;
    crc_ok = (n >= 4) && ({mq[n-1], mq[n-2], mq[n-3], mq[n-4]} == ref_fcs(mq, n - 4));
    in_rng = (n >= MINL) && (n <= lim);
    fld = (n >= 14) ? {mq[12], mq[13]} : 0;
    pay = n - 18;
    e_done = 1;
    e_good = m_sfd && !m_er && in_rng && crc_ok;
    if (m_sfd) begin
      e_sh = n < MINL;
      e_lg = (n > lim) && crc_ok;
      e_jb = (n > lim) && !crc_ok;
      e_fcs = in_rng && !crc_ok && !m_er && !pt;
      e_al = in_rng && !crc_ok && !m_er && pt;
      e_sy = m_er;
      e_lm = in_rng && crc_ok && !m_er && (fld < 16'h0600) &&
             ((n == MINL) ? (fld > pay) : (fld != pay));
    end
  endtask

  task automatic model_step();
    int lim;
    {e_v, e_ab, e_done, e_good, e_al, e_fcs, e_sh, e_lg, e_jb, e_sy, e_lm} = '0;
    e_d = d;
    if (!v) return;
    if (!m_in) begin
      m_jumbo = jumbo; m_sfd = (d == 8'hD5); m_drop = 0; m_er = er;
      mq.delete();
      if (m_sfd && er) begin e_ab = 1; m_drop = 1; end
      m_in = !eof;
      if (eof) finish_frame(part);
    end else begin
      mq.push_back(d);
      m_er = m_er | er;
      lim = m_jumbo ? MAXJ : MAXS;
      if (m_sfd && !m_drop && (er || mq.size() > lim)) begin e_ab = 1; m_drop = 1; end
      else if (m_sfd && !m_drop) e_v = 1;
      if (eof) begin m_in = 0; finish_frame(part); end
    end
  endtask

  task automatic beat(input bit vv, input logic [7:0] dd, input bit ee, input bit rr, input bit pp);
    v = vv; d = dd; eof = ee; er = rr; part = pp;
    model_step();
    @(posedge clk);
    #5;
    chk(o_v == e_v, "R3", "out_valid", o_v, e_v);
    if (e_v) chk(o_d == e_d, "R3", "out_data", o_d, e_d);
    chk(o_ab == e_ab, "R4 R5", "abort", o_ab, e_ab);
    chk(o_done == e_done, "R6", "done", o_done, e_done);
    chk(o_good == e_good, "R6 R2", "good", o_good, e_good);
    chk(s_fcs == e_fcs, "R7", "stat_fcs", s_fcs, e_fcs);
    chk(s_al == e_al, "R8", "stat_align", s_al, e_al);
    chk(s_sh == e_sh, "R9", "stat_short", s_sh, e_sh);
    chk(s_lg == e_lg, "R10 R12", "stat_long", s_lg, e_lg);
    chk(s_jb == e_jb, "R10", "stat_jabber", s_jb, e_jb);
    chk(s_sy == e_sy, "R4", "stat_symbol", s_sy, e_sy);
    chk(s_lm == e_lm, "R11", "stat_len_mis", s_lm, e_lm);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) beat(0, 8'h00, 0, 0, 0);
  endtask

  // er_at: 0 = delimiter beat, i+1 = frame byte i, -1 = none
  task automatic send_frame(input int n, input int field, input bit bad_crc,
                            input int er_at, input bit pt, input bit bad_sfd);
    logic [7:0] fb[$];
    logic [31:0] c;
    for (int i = 0; i < 6; i++) fb.push_back(8'h02 + 8'(i));
    for (int i = 0; i < 6; i++) fb.push_back(8'h30 + 8'(i));
    fb.push_back(8'(field >> 8));
    fb.push_back(8'(field));
    for (int i = 0; i < n - 18; i++) fb.push_back(8'(i * 7 + n));
    c = ref_fcs(fb, fb.size());
    for (int i = 0; i < 4; i++) fb.push_back(8'(c >> (8 * i)));
    if (bad_crc) fb[n-1] = fb[n-1] ^ 8'h01;
    beat(1, bad_sfd ? 8'h55 : 8'hD5, n == 0, er_at == 0, 0);
    for (int i = 0; i < n; i++) begin
      if (gap_on && (i % 5 == 3)) beat(0, 8'hEE, 0, 1, 0);
      if (i == flip_at) jumbo = ~jumbo;
      beat(1, fb[i], i == n - 1, er_at == i + 1, pt && (i == n - 1));
    end
    idle(2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    chk({o_v, o_ab, o_done, o_good, s_al, s_fcs, s_sh, s_lg, s_jb, s_sy, s_lm} == '0,
        "R1", "outputs in reset", 0, 0);
    rst_n = 1'b1;
    idle(2);
    chk({o_v, o_ab, o_done, o_good, s_al, s_fcs, s_sh, s_lg, s_jb, s_sy, s_lm} == '0,
        "R1", "outputs after reset", 0, 0);
    send_frame(64, 46, 0, -1, 0, 0);     // R6 minimum good
    send_frame(80, 16'h0800, 0, -1, 0, 0);
    send_frame(80, 62, 0, -1, 0, 0);     // R11 exact length
    send_frame(70, 40, 0, -1, 0, 0);     // R11 mismatch
    send_frame(64, 30, 0, -1, 0, 0);     // R11 padded
    send_frame(64, 50, 0, -1, 0, 0);     // R11 padded over
    send_frame(70, 16'h0800, 1, -1, 0, 0); // R7
    send_frame(70, 16'h0800, 1, -1, 1, 0); // R8 align
    send_frame(70, 16'h0800, 0, -1, 1, 0); // R8 partial ignored
    send_frame(40, 22, 0, -1, 0, 0);     // R9
    send_frame(0, 0, 0, -1, 0, 0);       // R9 empty
    send_frame(96, 16'h0800, 0, -1, 0, 0); // R5 at limit
    send_frame(100, 16'h0800, 0, -1, 0, 0); // R5 R10 long
    send_frame(110, 16'h0800, 1, -1, 0, 0); // R10 jabber
    send_frame(72, 16'h0800, 0, 30, 0, 0);  // R4 mid error
    send_frame(72, 16'h0800, 0, 0, 0, 0);   // R4 error on delimiter
    send_frame(72, 16'h0800, 0, -1, 0, 1);  // R2 bad delimiter
    send_frame(100, 16'h0800, 0, 20, 0, 1); // R2 bad delimiter with error
    gap_on = 1;
    send_frame(75, 57, 0, -1, 0, 0);        // R3 R4 gaps with stray error
    send_frame(75, 57, 1, -1, 0, 0);
    gap_on = 0;
    jumbo = 1'b1;
    send_frame(150, 16'h0800, 0, -1, 0, 0); // R12 jumbo accept
    send_frame(160, 16'h0800, 1, -1, 0, 0); // R12 jumbo at limit, bad crc
    send_frame(170, 16'h0800, 0, -1, 0, 0); // R12 jumbo overflow
    jumbo = 1'b0;
    flip_at = 10;
    send_frame(120, 16'h0800, 0, -1, 0, 0); // R12 mid-frame enable ignored
    flip_at = 10;
    send_frame(120, 16'h0800, 0, -1, 0, 0); // R12 mid-frame disable ignored
    flip_at = -1;
    jumbo = 1'b0;
    send_frame(64, 46, 0, -1, 0, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule